// File: doc/BRIEF.md
# Supervisor Trap Value Capture Unit

This unit holds two supervisor trap registers: the exception program counter (EPC) and the trap value (TVAL). In the clock cycle where the trap strobe is high, the EPC takes the address of the trapping instruction. In the same cycle, TVAL takes a value that depends on the cause class. For a bad-address cause it takes the faulting address. For an illegal-instruction cause it takes the instruction bits, cut to their own length. For every other cause it takes zero.

For an illegal instruction, the build-time parameter `CAPTURE_INSN` selects between two behaviours: record the instruction bits, or record zero. When the bits are recorded, the unit decodes the instruction length from the low encoding bits. It zero-fills TVAL above that length. If the instruction is wider than `XLEN`, TVAL keeps only its lowest-addressed `XLEN` bits.

Software reads and writes both registers through a small CSR port. The read is combinational. A write from software is accepted only in a cycle with no trap.

Each cycle, a combinational decode chooses one of four update actions. The registers then apply that action at the clock edge:
- `ACT_HOLD`: no trap and no mapped write. Both registers keep their values.
- `ACT_TRAP`: the strobe is high. Both registers are loaded from the trap inputs.
- `ACT_WR_EPC`: software writes the EPC.
- `ACT_WR_TVAL`: software writes TVAL.

The priority order is fixed: `ACT_TRAP` first, then the two write actions, then `ACT_HOLD`.

Top module: `trapval_capture`

## Requirements
- R1: A synchronous active-high reset clears EPC and TVAL to zero.
- R2: On a cycle with `trap_valid` high, the EPC is loaded with `trap_pc` at that clock edge, whatever the cause.
- R3: With `CAPTURE_INSN` = 0, a trap with cause 2 (illegal instruction) writes zero to TVAL.
- R4: With `CAPTURE_INSN` = 1, a trap with cause 2 writes the instruction into TVAL and clears every TVAL bit at or above the decoded length. The length is decoded from the low bits of `trap_insn` as follows:
  - bits[1:0] ≠ 11: 16 bits.
  - bits[1:0] = 11 and bits[4:2] ≠ 111: 32 bits.
  - bits[5:0] = 011111: 48 bits.
  - bits[6:0] = 0111111 or 1111111: all 64 supplied bits.
- R5: With `CAPTURE_INSN` = 1, an instruction longer than `XLEN` leaves only its low `XLEN` bits in TVAL. With `XLEN` = 32, a 48-bit or 64-bit instruction yields `trap_insn[31:0]`.
- R6: A trap with cause 0, 1, 4, 5, 6, 7, 12, 13 or 15 (misaligned, access or page fault) writes `trap_addr` into TVAL. The EPC still takes `trap_pc`, so the two may differ.
- R7: A trap with any cause not named in R3 to R6 writes zero into TVAL.
- R8: Without a trap, a write with `csr_wr_en` high stores `csr_wdata` into the EPC at address 0x141, or into TVAL at address 0x143. A write to any other address changes neither register.
- R9: When `trap_valid` and a CSR write fall in the same cycle, the trap values are stored in both registers and the software write is dropped.
- R10: `csr_rdata` shows the EPC when `csr_addr` is 0x141 and TVAL when it is 0x143, in the same cycle. It shows zero for any other address.
- R11: In a cycle with no trap and no write, both registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | Trap strobe, one cycle per trap |
| trap_cause | input | CAUSE_W | Exception cause code |
| trap_pc | input | XLEN | Address of the trapping instruction |
| trap_insn | input | 64 | Raw instruction bits, lowest parcel in the low bits |
| trap_addr | input | XLEN | Faulting address for address-class causes |
| csr_wr_en | input | 1 | Software write strobe |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | XLEN | Software write data |
| csr_rdata | output | XLEN | Combinational read data |

## Verification
Two functions can fall in the same cycle: a trap capture and a software CSR write. Directed cycles raise `trap_valid` together with a write to the EPC address, and together with a write to the TVAL address. A long stretch of random cycles then raises both strobes independently, with illegal causes carrying every length encoding. After each edge, the registers are read back through the CSR port and judged against a reference model in the bench. In that model, a trap overrides the write.

// File: rtl/trapval_pkg.sv
`timescale 1ns/1ps
package trapval_pkg;

    // Widest instruction the capture path accepts.
    localparam int ILEN = 64;

    localparam logic [11:0] CSR_EPC_ADDR  = 12'h141;
    localparam logic [11:0] CSR_TVAL_ADDR = 12'h143;

    // Source of the trap value for a given cause.
    typedef enum logic [1:0] {
        SRC_ZERO,
        SRC_INSN,
        SRC_ADDR
    } tval_src_e;

    // Decoded instruction length class.
    typedef enum logic [1:0] {
        ILEN_16,
        ILEN_32,
        ILEN_48,
        ILEN_64
    } ilen_e;

    // Register update action chosen each cycle.
    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_TRAP,
        ACT_WR_EPC,
        ACT_WR_TVAL
    } upd_act_e;

endpackage

// File: rtl/trapval_ilen_decode.sv
`timescale 1ns/1ps
module trapval_ilen_decode
    import trapval_pkg::*;
(
    input  logic [6:0] enc_lo,
    output ilen_e      len
);

    always_comb begin
        if (enc_lo[1:0] != 2'b11) begin
            len = ILEN_16;
        end else if (enc_lo[4:2] != 3'b111) begin
            len = ILEN_32;
        end else if (!enc_lo[5]) begin
            len = ILEN_48;
        end else begin
            // 64-bit and longer forms: all supplied bits are kept.
            len = ILEN_64;
        end
    end

endmodule

// File: rtl/trapval_cause_class.sv
`timescale 1ns/1ps
module trapval_cause_class
    import trapval_pkg::*;
#(
    parameter int CAUSE_W = 5
) (
    input  logic [CAUSE_W-1:0] cause,
    output tval_src_e          src
);

    logic [31:0] cause_ext;
    assign cause_ext = 32'(cause);

    always_comb begin
        unique case (cause_ext)
            32'd0, 32'd1, 32'd4, 32'd5, 32'd6, 32'd7,
            32'd12, 32'd13, 32'd15: src = SRC_ADDR;
            32'd2:                  src = SRC_INSN;
            default:                src = SRC_ZERO;
        endcase
    end

endmodule

// File: rtl/trapval_insn_fold.sv
`timescale 1ns/1ps
module trapval_insn_fold
    import trapval_pkg::*;
#(
    parameter int XLEN         = 64,
    parameter bit CAPTURE_INSN = 1'b1
) (
    input  logic [ILEN-1:0] insn,
    input  ilen_e           len,
    output logic [XLEN-1:0] val
);

    generate
        if (CAPTURE_INSN) begin : g_capture
            logic [7:0] keep_bits;

            always_comb begin
                unique case (len)
                    ILEN_16: keep_bits = 8'd16;
                    ILEN_32: keep_bits = 8'd32;
                    ILEN_48: keep_bits = 8'd48;
                    ILEN_64: keep_bits = 8'd64;
                    default: keep_bits = 8'd0;
                endcase
            end

            // Bits above XLEN are never produced, which truncates
            // instructions wider than XLEN to their low part.
            for (genvar i = 0; i < XLEN; i++) begin : g_bit
                assign val[i] = insn[i] & (8'(i) < keep_bits);
            end
        end else begin : g_zero
            assign val = '0;
        end
    endgenerate

endmodule

// File: rtl/trapval_capture.sv
`timescale 1ns/1ps
module trapval_capture
    import trapval_pkg::*;
#(
    parameter int XLEN         = 64,
    parameter int CAUSE_W      = 5,
    parameter bit CAPTURE_INSN = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trap_valid,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    trap_pc,
    input  logic [ILEN-1:0]    trap_insn,
    input  logic [XLEN-1:0]    trap_addr,
    input  logic               csr_wr_en,
    input  logic [11:0]        csr_addr,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata
);

    logic [XLEN-1:0] epc_q;
    logic [XLEN-1:0] tval_q;
    logic [XLEN-1:0] tval_next;
    logic [XLEN-1:0] insn_val;
    ilen_e           insn_len;
    tval_src_e       tval_src;
    upd_act_e        act;

    trapval_ilen_decode u_ilen (
        .enc_lo (trap_insn[6:0]),
        .len    (insn_len)
    );

    trapval_cause_class #(
        .CAUSE_W (CAUSE_W)
    ) u_class (
        .cause (trap_cause),
        .src   (tval_src)
    );

    trapval_insn_fold #(
        .XLEN         (XLEN),
        .CAPTURE_INSN (CAPTURE_INSN)
    ) u_fold (
        .insn (trap_insn),
        .len  (insn_len),
        .val  (insn_val)
    );

    always_comb begin
        unique case (tval_src)
            SRC_INSN: tval_next = insn_val;
            SRC_ADDR: tval_next = trap_addr;
            default:  tval_next = '0;
        endcase
    end

    // Update action: the trap outranks any software write.
    always_comb begin
        if (trap_valid) begin
            act = ACT_TRAP;
        end else if (csr_wr_en && csr_addr == CSR_EPC_ADDR) begin
            act = ACT_WR_EPC;
        end else if (csr_wr_en && csr_addr == CSR_TVAL_ADDR) begin
            act = ACT_WR_TVAL;
        end else begin
            act = ACT_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q  <= '0;
            tval_q <= '0;
        end else begin
            unique case (act)
                ACT_TRAP: begin
                    epc_q  <= trap_pc;
                    tval_q <= tval_next;
                end
                ACT_WR_EPC:  epc_q  <= csr_wdata;
                ACT_WR_TVAL: tval_q <= csr_wdata;
                default: begin
                    epc_q  <= epc_q;
                    tval_q <= tval_q;
                end
            endcase
        end
    end

    always_comb begin
        unique case (csr_addr)
            CSR_EPC_ADDR:  csr_rdata = epc_q;
            CSR_TVAL_ADDR: csr_rdata = tval_q;
            default:       csr_rdata = '0;
        endcase
    end

endmodule

// File: rtl/trapval_capture_chk.sv
`timescale 1ns/1ps
module trapval_capture_chk #(
    parameter int XLEN         = 64,
    parameter int CAUSE_W      = 5,
    parameter bit CAPTURE_INSN = 1'b1
) (
    input logic               clk,
    input logic               rst,
    input logic               trap_valid,
    input logic [CAUSE_W-1:0] trap_cause,
    input logic [XLEN-1:0]    trap_pc,
    input logic [XLEN-1:0]    trap_addr,
    input logic [1:0]         trap_insn_lo,
    input logic               csr_wr_en,
    input logic [XLEN-1:0]    epc_q,
    input logic [XLEN-1:0]    tval_q
);

    logic is_illegal;
    logic is_addr_fault;

    assign is_illegal    = (trap_cause == CAUSE_W'(2));
    assign is_addr_fault = (trap_cause == CAUSE_W'(0))  || (trap_cause == CAUSE_W'(1))  ||
                           (trap_cause == CAUSE_W'(4))  || (trap_cause == CAUSE_W'(5))  ||
                           (trap_cause == CAUSE_W'(6))  || (trap_cause == CAUSE_W'(7))  ||
                           (trap_cause == CAUSE_W'(12)) || (trap_cause == CAUSE_W'(13)) ||
                           (trap_cause == CAUSE_W'(15));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (epc_q == '0 && tval_q == '0));

    // R2
    epc_load_chk: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> epc_q == $past(trap_pc));

    // R3
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && is_illegal && !CAPTURE_INSN) |=> tval_q == '0);

    // R4
    short_insn_upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && is_illegal && trap_insn_lo != 2'b11) |=> tval_q[XLEN-1:16] == '0);

    // R6
    addr_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && is_addr_fault) |=> tval_q == $past(trap_addr));

    // R7
    other_cause_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && !is_addr_fault && !is_illegal) |=> tval_q == '0);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!trap_valid && !csr_wr_en) |=> ($stable(epc_q) && $stable(tval_q)));

endmodule

bind trapval_capture trapval_capture_chk #(
    .XLEN         (XLEN),
    .CAUSE_W      (CAUSE_W),
    .CAPTURE_INSN (CAPTURE_INSN)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .trap_valid   (trap_valid),
    .trap_cause   (trap_cause),
    .trap_pc      (trap_pc),
    .trap_addr    (trap_addr),
    .trap_insn_lo (trap_insn[1:0]),
    .csr_wr_en    (csr_wr_en),
    .epc_q        (epc_q),
    .tval_q       (tval_q)
);

// File: tb/trapval_capture_bench.sv
`timescale 1ns/1ps
module trapval_capture_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trap_valid = 1'b0;
    logic [4:0]  trap_cause = '0;
    logic [63:0] trap_pc = '0;
    logic [63:0] trap_insn = '0;
    logic [63:0] trap_addr = '0;
    logic        csr_wr_en = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] rd_a;
    logic [31:0] rd_b;
    logic [63:0] rd_c;

    int n_vec = 0;
    int n_bad = 0;

    // Reference state for the three builds: 64/capture, 32/capture, 64/no capture.
    logic [63:0] m_epc  [3];
    logic [63:0] m_tval [3];
    int          m_xl   [3] = '{64, 32, 64};
    bit          m_cap  [3] = '{1'b1, 1'b1, 1'b0};

    always #2 clk = ~clk;

    trapval_capture u_trapval_capture (
        .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_cause(trap_cause),
        .trap_pc(trap_pc), .trap_insn(trap_insn), .trap_addr(trap_addr),
        .csr_wr_en(csr_wr_en), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(rd_a)
    );

    trapval_capture #(.XLEN(32)) u_trapval_capture_x32 (
        .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_cause(trap_cause),
        .trap_pc(trap_pc[31:0]), .trap_insn(trap_insn), .trap_addr(trap_addr[31:0]),
        .csr_wr_en(csr_wr_en), .csr_addr(csr_addr), .csr_wdata(csr_wdata[31:0]),
        .csr_rdata(rd_b)
    );

    trapval_capture #(.CAPTURE_INSN(1'b0)) u_trapval_capture_nocap (
        .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_cause(trap_cause),
        .trap_pc(trap_pc), .trap_insn(trap_insn), .trap_addr(trap_addr),
        .csr_wr_en(csr_wr_en), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(rd_c)
    );

    function automatic logic [63:0] xmask(int xl);
        return (xl == 64) ? {64{1'b1}} : 64'h0000_0000_FFFF_FFFF;
    endfunction

    function automatic logic [63:0] ref_tval(int xl, bit cap, logic [4:0] c,
                                             logic [63:0] insn, logic [63:0] a);
        logic [63:0] res = '0;
        int len;
        if (c == 5'd2) begin
            if (!cap) return '0;
            if (insn[1:0] != 2'b11)      len = 16;
            else if (insn[4:2] != 3'b111) len = 32;
            else if (!insn[5])            len = 48;
            else                          len = 64;
            for (int i = 0; i < len && i < xl; i++) res[i] = insn[i];
            return res;
        end
        if (c inside {5'd0, 5'd1, 5'd4, 5'd5, 5'd6, 5'd7, 5'd12, 5'd13, 5'd15})
            return a & xmask(xl);
        return '0;
    endfunction

    function automatic logic [63:0] dut_rd(int k);
        if (k == 0) return rd_a;
        if (k == 1) return {32'b0, rd_b};
        return rd_c;
    endfunction

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cycle(string tag, logic r, logic tv, logic [4:0] c, logic [63:0] p,
                         logic [63:0] ins, logic [63:0] a, logic w, logic [11:0] wa,
                         logic [63:0] wd);
        rst = r; trap_valid = tv; trap_cause = c; trap_pc = p; trap_insn = ins;
        trap_addr = a; csr_wr_en = w; csr_addr = wa; csr_wdata = wd;
        @(posedge clk);
        for (int k = 0; k < 3; k++) begin
            if (r) begin
                m_epc[k] = '0; m_tval[k] = '0;
            end else if (tv) begin
                m_epc[k]  = p & xmask(m_xl[k]);
                m_tval[k] = ref_tval(m_xl[k], m_cap[k], c, ins, a);
            end else if (w && wa == 12'h141) begin
                m_epc[k] = wd & xmask(m_xl[k]);
            end else if (w && wa == 12'h143) begin
                m_tval[k] = wd & xmask(m_xl[k]);
            end
        end
        #1;
        trap_valid = 1'b0; csr_wr_en = 1'b0; csr_addr = 12'h141;
        #1;
        for (int k = 0; k < 3; k++) check(tag, $sformatf("epc[%0d]", k), dut_rd(k), m_epc[k]);
        csr_addr = 12'h143;
        #1;
        for (int k = 0; k < 3; k++) check(tag, $sformatf("tval[%0d]", k), dut_rd(k), m_tval[k]);
        csr_addr = 12'h140;
        #0.5;
        for (int k = 0; k < 3; k++) check("R10", $sformatf("unmapped[%0d]", k), dut_rd(k), '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [4:0] causes [12] = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5,
                                    5'd8, 5'd12, 5'd13, 5'd15, 5'd2, 5'd2};
        logic [11:0] waddrs [3] = '{12'h141, 12'h143, 12'h142};
        for (int k = 0; k < 3; k++) begin m_epc[k] = 'x; m_tval[k] = 'x; end

        // R1 reset state
        cycle("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0);
        cycle("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0);
        // R8 software writes and an unmapped write
        cycle("R8", 0, 0, 0, 0, 0, 0, 1, 12'h141, 64'h1111_2222_3333_4444);
        cycle("R8", 0, 0, 0, 0, 0, 0, 1, 12'h143, 64'h5555_6666_7777_8888);
        cycle("R8", 0, 0, 0, 0, 0, 0, 1, 12'h142, 64'hFFFF_FFFF_FFFF_FFFF);
        // R11 idle hold
        cycle("R11", 0, 0, 0, 0, 0, 0, 0, 12'h143, 0);
        // R4 16-bit and 32-bit illegal instructions, R3 via no-capture build
        cycle("R4", 0, 1, 5'd2, 64'h8000_1000, 64'hDEAD_BEEF_CAFE_1234, 64'h9, 0, 0, 0);
        cycle("R3", 0, 1, 5'd2, 64'h8000_1004, 64'hFFFF_FFFF_8765_4333, 64'h9, 0, 0, 0);
        // R5 48-bit, 64-bit and longer forms (truncated in the 32-bit build)
        cycle("R5", 0, 1, 5'd2, 64'h8000_1008, 64'hAAAA_5555_6666_779F, 0, 0, 0, 0);
        cycle("R5", 0, 1, 5'd2, 64'h8000_1010, 64'h1234_5678_9ABC_DE3F, 0, 0, 0, 0);
        cycle("R5", 0, 1, 5'd2, 64'h8000_1018, 64'h0F0F_F0F0_A5A5_5A7F, 0, 0, 0, 0);
        // R6 address faults: TVAL differs from EPC
        cycle("R6", 0, 1, 5'd12, 64'h8000_2000, 0, 64'h8000_2002, 0, 0, 0);
        cycle("R6", 0, 1, 5'd5, 64'h8000_2004, 0, 64'hCAFE_0000_1234_5671, 0, 0, 0);
        cycle("R2", 0, 1, 5'd15, 64'hFFFF_FFC0_0000_0010, 0, 64'h7, 0, 0, 0);
        // R7 other causes
        cycle("R7", 0, 1, 5'd3, 64'h10, 64'h1234, 64'h55, 0, 0, 0);
        cycle("R7", 0, 1, 5'd8, 64'h20, 64'h1234, 64'h55, 0, 0, 0);
        // R9 trap together with a software write to each register
        cycle("R9", 0, 1, 5'd13, 64'hABC0, 0, 64'hABCD, 1, 12'h141, 64'hDEAD);
        cycle("R9", 0, 1, 5'd2, 64'hABC4, 64'h0000_0000_0000_4B33, 0, 1, 12'h143, 64'hBEEF);
        // R1 reset after activity
        cycle("R1", 1, 1, 5'd0, 64'h44, 0, 64'h48, 1, 12'h141, 64'h1);

        for (int n = 0; n < 400; n++) begin
            logic        tv = ($urandom_range(0, 2) != 0);
            logic        w  = ($urandom_range(0, 1) != 0);
            logic [4:0]  c  = causes[$urandom_range(0, 11)];
            logic [63:0] ins = {$urandom, $urandom};
            string       t;
            if (tv && w)                   t = "R9";
            else if (tv && c == 5'd2)      t = "R4";
            else if (tv && (c == 5'd3 || c == 5'd8)) t = "R7";
            else if (tv)                   t = "R6";
            else if (w)                    t = "R8";
            else                           t = "R11";
            cycle(t, 0, tv, c, {$urandom, $urandom}, ins, {$urandom, $urandom},
                  w, waddrs[$urandom_range(0, 2)], {$urandom, $urandom});
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule